// File: doc/BRIEF.md
# Two-Wire Bus Target with Clock Stretching

This block is a target (slave) on a two-wire serial bus made of a clock line and a data line, both open-drain and pulled high. It answers to a single fixed 7-bit address. It watches the lines for the framing conditions and collects the first byte after each START into an address and a direction bit. If the address matches its own, it pulls the data line low for the acknowledge pulse. After that it either takes in bytes that the controller writes or sends out bytes that the local logic supplies. General-call, 10-bit addressing and alternative message formats are not supported.

On the local side there are two byte streams. Received bytes come out on `rx_byte` with a one-cycle `rx_valid` strobe. Transmitted bytes are read from `tx_byte`; `tx_taken` pulses in the cycle the byte is captured, and local logic must then present the next byte. A single `local_ready` input applies back-pressure to both streams. If `local_ready` is low when a byte's acknowledge pulse ends, the target holds the clock line low, stalling the controller until `local_ready` rises. If `local_ready` is low when a written byte completes, the target refuses that byte with a not-acknowledge instead.

The pins `scl_pull` and `sda_pull` mean "pull the line low". Outside the block, each is combined with an open-drain pad. The line inputs pass through a synchronizer, so all bus timing is judged on the system clock.

Top module: `twi_target`

## Requirements
- R1: After reset, neither line is pulled low and both `rx_valid` and `tx_taken` are low.
- R2: A START or repeated START (data falling while clock is high) abandons any partly shifted byte and begins a new address byte.
- R3: A STOP (data rising while clock is high) returns the target to idle. Bytes clocked afterwards without a new START get no acknowledge and produce no `rx_valid`.
- R4: The first byte after a START is taken most significant bit first. Bits [7:1] are the address and bit 0 is the direction, where 1 means the target transmits and 0 means the controller writes. On a match, the target pulls the data line low for the ninth clock pulse.
- R5: On an address mismatch, the data line is left released for the acknowledge pulse, and the rest of that transaction is ignored.
- R6: Each written byte is assembled most significant bit first and acknowledged. It appears on `rx_byte` with `rx_valid` high for exactly one cycle.
- R7: If `local_ready` is low when a written byte's eighth bit ends, that byte gets no acknowledge and no `rx_valid`, and the target ignores the bus until the next START or STOP.
- R8: If `local_ready` is low when an acknowledge pulse ends, the target holds the clock line low. It releases the line in the cycle after it sees `local_ready` high, and it never pulls both lines at once.
- R9: In a read, the target captures `tx_byte` when it leaves the acknowledge phase with `local_ready` high, pulses `tx_taken` in that cycle, and shifts the byte out most significant bit first.
- R10: After the controller gives a not-acknowledge (data high on the ninth pulse) to a transmitted byte, the target releases the data line and drives nothing until the next START or STOP.
- R11: The target begins pulling a line low only while the synchronized clock is low, so its data output never changes during a clock-high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Clock line level as seen on the pad |
| sda_in | input | 1 | Data line level as seen on the pad |
| scl_pull | output | 1 | 1 pulls the clock line low (stretch) |
| sda_pull | output | 1 | 1 pulls the data line low |
| rx_byte | output | 8 | Last accepted written byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| tx_byte | input | 8 | Next byte to transmit |
| tx_taken | output | 1 | One-cycle strobe: `tx_byte` was captured |
| local_ready | input | 1 | Local side can accept or supply a byte |

## Verification
Back-pressure from `local_ready` and the end of an acknowledge pulse can fall in the same cycle. The target then has to choose in one step between stalling the clock and releasing it while loading the next transmit byte. The bench provokes this by lowering `local_ready` just before an address acknowledge, so that the clock is held, and raising it several hundred cycles later while the controller model is waiting on the stretched line. It judges the result by the measured length of the stall, by whether the clock is pulled low partway through the stall, and by the scoreboard receiving the following byte intact. A second overlap, a START arriving while a data byte is half shifted, is checked by the scoreboard seeing only the byte sent after the restart.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_HOLD,
    ST_SKIP
  } twi_state_e;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  // Framing conditions: data moves while clock stays high.
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-2:0] OWN_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              local_ready,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              tx_taken
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W + 1);

  twi_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] tx_sh;
  logic              rd_dir;
  logic              ctl_nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rd_dir   <= 1'b0;
      ctl_nack <= 1'b0;
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      tx_taken <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_taken <= 1'b0;
      if (stop_ev) begin
        st       <= ST_IDLE;
        scl_pull <= 1'b0;
        sda_pull <= 1'b0;
      end else if (start_ev) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        scl_pull <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt < LAST_BIT) begin
              rx_sh <= {rx_sh[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              if (st == ST_ADDR) begin
                if (rx_sh[DATA_W-1:1] == OWN_ADDR) begin
                  sda_pull <= 1'b1;
                  rd_dir   <= rx_sh[0];
                  st       <= ST_ADDR_ACK;
                end else begin
                  st <= ST_SKIP;
                end
              end else if (local_ready) begin
                sda_pull <= 1'b1;
                rx_byte  <= rx_sh;
                rx_valid <= 1'b1;
                st       <= ST_WR_ACK;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == ACK_BIT) begin
              sda_pull <= 1'b0;
              scl_pull <= ~local_ready;
              st       <= ST_HOLD;
            end
          end
          ST_HOLD: begin
            if (local_ready) begin
              scl_pull <= 1'b0;
              cnt      <= '0;
              if (rd_dir) begin
                tx_sh    <= tx_byte;
                sda_pull <= ~tx_byte[DATA_W-1];
                tx_taken <= 1'b1;
                st       <= ST_RD;
              end else begin
                st <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_pull <= 1'b0;
                st       <= ST_RD_ACK;
              end else begin
                tx_sh    <= {tx_sh[DATA_W-2:0], 1'b0};
                sda_pull <= ~tx_sh[DATA_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              ctl_nack <= sda_s;
              cnt      <= cnt + 1'b1;
            end else if (scl_fall && cnt == ACK_BIT) begin
              if (ctl_nack) begin
                st <= ST_SKIP;
              end else begin
                scl_pull <= ~local_ready;
                st       <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twi_target.sv
module twi_target #(
  parameter int             DATA_W      = 8,
  parameter int             SYNC_STAGES = 2,
  parameter logic [DATA_W-2:0] OWN_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_taken,
  input  logic              local_ready
);

  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_ev, stop_ev;

  twi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_in, sda_in}),
    .dout (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  twi_bus_events u_ev (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  twi_ctrl #(.DATA_W(DATA_W), .OWN_ADDR(OWN_ADDR)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .local_ready(local_ready),
    .tx_byte    (tx_byte),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .tx_taken   (tx_taken)
  );

endmodule

// File: rtl/twi_target_chk.sv
module twi_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_pull,
  input logic sda_pull,
  input logic rx_valid,
  input logic tx_taken,
  input logic local_ready
);

  // R11
  sda_low_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (!scl_s && $past(!scl_s)));

  // R11
  scl_low_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> !scl_s);

  // R8
  stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && local_ready) |=> !scl_pull);

  // R8
  no_dual_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_pull && sda_pull));

  // R6
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9
  tx_take_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |-> $past(local_ready));

endmodule

bind twi_target twi_target_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .scl_pull   (scl_pull),
  .sda_pull   (sda_pull),
  .rx_valid   (rx_valid),
  .tx_taken   (tx_taken),
  .local_ready(local_ready)
);

// File: tb/sim_twi_target.sv
module sim_twi_target;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 24;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_pull, sda_pull, rx_valid, tx_taken;
  logic [7:0] rx_byte;
  logic [7:0] tx_byte = 8'h00;
  logic       local_ready = 1'b1;
  wire        scl_bus = scl_m & ~scl_pull;
  wire        sda_bus = sda_m & ~sda_pull;

  int vectors = 0, fails = 0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_src[$];
  int taken_cnt = 0;
  int hold_run = 0, hold_max = 0;
  int line_viol = 0;
  logic prev_scl = 1'b1, prev_sdap = 1'b0, prev_sclp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .tx_byte(tx_byte), .tx_taken(tx_taken),
    .local_ready(local_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor for written bytes (R6), plus local transmit side (R9).
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rx_q.size() == 0) check("R6 unexpected rx_valid", {24'h0, rx_byte}, 32'hFFFF_FFFF);
      else check("R6 rx byte", {24'h0, rx_byte}, {24'h0, rx_q.pop_front()});
    end
    if (rst_n && tx_taken) begin
      taken_cnt++;
      tx_byte <= (tx_src.size() != 0) ? tx_src.pop_front() : 8'hEE;
    end
    hold_run = scl_pull ? hold_run + 1 : 0;
    if (hold_run > hold_max) hold_max = hold_run;
    // R11: no pull change while the clock line stays high
    if (rst_n && scl_bus && prev_scl && (sda_pull != prev_sdap || (scl_pull && !prev_sclp)))
      line_viol++;
    prev_scl  = scl_bus;
    prev_sdap = sda_pull;
    prev_sclp = scl_pull;
  end

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic write_bit(input logic b);
    sda_m = b; hp();
    scl_m = 1'b1; wait (scl_bus === 1'b1); @(negedge clk); hp();
    scl_m = 1'b0; hp();
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; hp();
    scl_m = 1'b1; wait (scl_bus === 1'b1); @(negedge clk);
    repeat (H/2) @(negedge clk);
    b = sda_bus;
    repeat (H/2) @(negedge clk);
    scl_m = 1'b0; hp();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp();
    scl_m = 1'b1; wait (scl_bus === 1'b1); hp();
    sda_m = 1'b0; hp();
    scl_m = 1'b0; hp();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp();
    scl_m = 1'b1; wait (scl_bus === 1'b1); hp();
    sda_m = 1'b1; hp();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) write_bit(b[i]);
    read_bit(a);
    acked = ~a;
  endtask

  task automatic read_byte(output logic [7:0] b, input logic give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      read_bit(x);
      b[i] = x;
    end
    write_bit(~give_ack);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 scl_pull", {31'h0, scl_pull}, 0);
    check("R1 sda_pull", {31'h0, sda_pull}, 0);
    check("R1 rx_valid", {31'h0, rx_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 tx_taken", {31'h0, tx_taken}, 0);

    // R4 / R6: write transaction
    bus_start();
    write_byte(8'h54, ack); check("R4 addr ack write", {31'h0, ack}, 1);
    rx_q.push_back(8'hA5); write_byte(8'hA5, ack); check("R6 ack A5", {31'h0, ack}, 1);
    rx_q.push_back(8'h3C); write_byte(8'h3C, ack); check("R6 ack 3C", {31'h0, ack}, 1);
    rx_q.push_back(8'h0F); write_byte(8'h0F, ack); check("R6 ack 0F", {31'h0, ack}, 1);
    bus_stop();

    // R5: mismatch
    bus_start();
    write_byte(8'h56, ack); check("R5 mismatch nack", {31'h0, ack}, 0);
    write_byte(8'h00, ack); check("R5 ignored byte", {31'h0, ack}, 0);
    bus_stop();

    // R7: not ready at end of written byte
    bus_start();
    write_byte(8'h54, ack); check("R4 addr ack", {31'h0, ack}, 1);
    rx_q.push_back(8'h11); write_byte(8'h11, ack); check("R6 ack 11", {31'h0, ack}, 1);
    local_ready = 1'b0;
    write_byte(8'h22, ack); check("R7 refused byte", {31'h0, ack}, 0);
    write_byte(8'h33, ack); check("R7 after refusal", {31'h0, ack}, 0);
    local_ready = 1'b1;
    bus_stop();

    // R8: clock stretch after address acknowledge
    hold_max = 0;
    local_ready = 1'b0;
    bus_start();
    write_byte(8'h54, ack); check("R8 addr ack", {31'h0, ack}, 1);
    fork
      begin
        repeat (200) @(negedge clk);
        check("R8 clock held", {31'h0, scl_pull}, 1);
        repeat (200) @(negedge clk);
        local_ready = 1'b1;
      end
    join_none
    rx_q.push_back(8'h99); write_byte(8'h99, ack); check("R8 ack after stall", {31'h0, ack}, 1);
    check("R8 stall length", {31'h0, (hold_max >= 350 && hold_max < 460)}, 1);
    bus_stop();

    // R9 / R10: read transaction
    tx_byte = 8'hC3;
    tx_src.push_back(8'h5A); tx_src.push_back(8'h81); tx_src.push_back(8'h00);
    taken_cnt = 0;
    bus_start();
    write_byte(8'h55, ack); check("R4 addr ack read", {31'h0, ack}, 1);
    read_byte(b, 1'b1); check("R9 read byte0", {24'h0, b}, 32'hC3);
    read_byte(b, 1'b1); check("R9 read byte1", {24'h0, b}, 32'h5A);
    read_byte(b, 1'b0); check("R9 read byte2", {24'h0, b}, 32'h81);
    check("R9 taken count", taken_cnt, 3);
    read_byte(b, 1'b1); check("R10 silent after nack", {24'h0, b}, 32'hFF);
    check("R10 no capture after nack", taken_cnt, 3);
    bus_stop();

    // R2: repeated START mid-byte
    bus_start();
    write_byte(8'h54, ack); check("R2 addr ack", {31'h0, ack}, 1);
    write_bit(1'b1); write_bit(1'b0); write_bit(1'b1); write_bit(1'b1);
    bus_start();
    write_byte(8'h54, ack); check("R2 addr after restart", {31'h0, ack}, 1);
    rx_q.push_back(8'h6E); write_byte(8'h6E, ack); check("R2 byte after restart", {31'h0, ack}, 1);
    bus_stop();

    // R3: STOP mid-byte, then bytes without START are ignored
    bus_start();
    write_byte(8'h54, ack); check("R3 addr ack", {31'h0, ack}, 1);
    write_bit(1'b0); write_bit(1'b1); write_bit(1'b0);
    bus_stop();
    scl_m = 1'b0; hp();
    write_byte(8'h54, ack); check("R3 no start no ack", {31'h0, ack}, 0);
    write_byte(8'h77, ack); check("R3 still idle", {31'h0, ack}, 0);
    bus_start();
    write_byte(8'h54, ack); check("R3 fresh start ack", {31'h0, ack}, 1);
    rx_q.push_back(8'h42); write_byte(8'h42, ack); check("R3 fresh byte ack", {31'h0, ack}, 1);
    bus_stop();

    repeat (20) @(negedge clk);
    check("R6 scoreboard drained", rx_q.size(), 0);
    check("R11 pull changes only with clock low", line_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule